// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the two error counters of a CAN node and decides, from them, whether the node may take a full part in bus traffic (error active), may only signal errors passively (error passive), or must stay off the bus (bus off). The protocol engine feeds it single-cycle event pulses. These pulses report a transmit error, a receive error, a frame sent without error, a frame received without error, and a run of 11 consecutive recessive bits seen on the bus.

All of its results leave the block in one read-only 32-bit status word. The word holds both counters, a two-bit state code and two early-warning flags that rise when a counter reaches 96. While the node is bus off, the transmit counter stays pinned at 255. The receive counter then counts idle recessive runs, and the 128th such run brings the node back to error active with both counters cleared.

Top module: `can_fault_conf`

## Requirements
- R1: While `rst_n` is low at a clock edge, every status bit is cleared after that edge, so the node starts error active with both counters at 0.
- R2: Outside bus off, a transmit error adds 8 to the transmit counter (status bits 7:0) when the sum is 255 or less.
- R3: Outside bus off, a successful transmit subtracts 1 from the transmit counter and never takes it below 0. When a transmit error and a successful transmit arrive in the same cycle, only the error counts.
- R4: Outside bus off, a receive error adds 1 to the receive counter (status bits 15:8) and holds it at 255 without wrapping. A successful receive subtracts 1 and never takes it below 0. When both arrive in the same cycle, only the error counts.
- R5: The state code in status bits 17:16 reads 2'b00 (error active) when both counters are below 128. It reads 2'b01 (error passive) when either counter is 128 or more and the node is not bus off. It reads 2'b10 in bus off.
- R6: Status bit 18 is 1 exactly when the transmit counter is 96 or more. Status bit 19 is 1 exactly when the receive counter is 96 or more.
- R7: A transmit error that would take the transmit counter past 255 puts the node in bus off. In the same update it sets the transmit counter to 255 and clears the receive counter.
- R8: In bus off, transmit errors, receive errors, successful transmits and successful receives change nothing, and the transmit counter stays at 255.
- R9: An idle pulse (11 recessive bits) adds 1 to the receive counter in bus off and has no effect outside bus off.
- R10: The idle pulse that brings the bus-off idle count to 128 clears both counters and returns the node to error active.
- R11: Status bits 31:20 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_tx_err | input | 1 | One-cycle pulse: transmit error detected |
| ev_rx_err | input | 1 | One-cycle pulse: receive error detected |
| ev_tx_ok | input | 1 | One-cycle pulse: frame transmitted without error |
| ev_rx_ok | input | 1 | One-cycle pulse: frame received without error |
| ev_idle11 | input | 1 | One-cycle pulse: 11 consecutive recessive bits seen |
| status_word | output | 32 | Packed counters, state code and warning flags |

## Verification
The situation hardest to reach from the ports is the return from bus off. The node first needs more than thirty transmit errors that no success cancels, which brings the transmit counter to 248. The next error trips bus off. After that it needs exactly 127 idle pulses, each of which must leave the node in bus off, before the 128th pulse recovers it. The stimulus walks this path on purpose. Along the way it injects every other event type while the node is bus off, and it sends idle pulses before bus off to show they are ignored there. A behavioural model in the bench then follows a long run of random event mixes, weighted towards transmit errors so that bus off is entered and left several times, and it compares the whole status word on every clock.

// File: rtl/can_fc_pkg.sv
// Package: shared widths, field positions and state encoding for the
// CAN fault confinement unit. Assumes 8-bit counters as packed in the
// 32-bit status word.
package can_fc_pkg;
    parameter int CNT_W    = 8;
    parameter int STATUS_W = 32;

    // Field positions inside the status word
    localparam int TEC_LSB   = 0;
    localparam int REC_LSB   = TEC_LSB + CNT_W;
    localparam int STATE_LSB = REC_LSB + CNT_W;
    localparam int TWARN_BIT = STATE_LSB + 2;
    localparam int RWARN_BIT = TWARN_BIT + 1;
    localparam int USED_W    = RWARN_BIT + 1;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'b00,
        FC_PASSIVE = 2'b01,
        FC_BUSOFF  = 2'b10
    } fc_state_e;
endpackage

// File: rtl/can_fc_tx_cnt.sv
// Module: transmit error counter.
// Adds a fixed step on each transmit error and takes one off on each
// successful transmit, never going below zero. It raises a trip pulse when an
// error would push the count past its maximum, and loads the maximum at that
// point. Assumes bus_off and recover come from the state keeper and the
// receive counter in the same cycle domain.
module can_fc_tx_cnt #(
    parameter int CNT_W   = 8,
    parameter int TX_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err,
    input  logic             tx_ok,
    input  logic             bus_off,
    input  logic             recover,
    output logic [CNT_W-1:0] tec,
    output logic             trip
);
    localparam logic [CNT_W:0]   MAX_W   = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CNT_W:0]   STEP_W  = (CNT_W+1)'(TX_STEP);
    localparam logic [CNT_W-1:0] STEP_N  = CNT_W'(TX_STEP);
    localparam logic [CNT_W-1:0] MAX_N   = {CNT_W{1'b1}};

    logic [CNT_W:0] sum;

    // Trip detection: the step would overflow the counter while on the bus
    always_comb begin
        sum  = {1'b0, tec} + STEP_W;
        trip = !bus_off && tx_err && (sum > MAX_W);
    end

    // Counter update; recovery clears, bus off freezes, error beats success
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tec <= '0;
        end else if (recover) begin
            tec <= '0;
        end else if (bus_off) begin
            tec <= tec;
        end else if (tx_err) begin
            tec <= trip ? MAX_N : sum[CNT_W-1:0];
        end else if (tx_ok && (tec != '0)) begin
            tec <= tec - 1'b1;
        end
    end

    // R2: a transmit error that fits adds exactly the step
    a_r2_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_off && tx_err && !trip && !recover) |=> (tec == $past(tec) + STEP_N));

    // R3: success at zero never wraps
    a_r3_tx_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_off && tx_ok && !tx_err && tec == '0) |=> (tec == '0));

    // R8: the counter sits at its maximum for the whole of bus off
    a_r8_tx_pinned: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off |-> (tec == MAX_N));
endmodule

// File: rtl/can_fc_rx_cnt.sv
// Module: receive error counter, which doubles as the idle-run counter in bus off.
// On the bus it adds one per receive error, holding at the maximum, and takes one
// off per successful receive, never going below zero. In bus off it counts
// idle pulses and raises recover on the pulse that completes the
// recovery count. Assumes trip and bus_off come from the transmit
// counter and the state keeper.
module can_fc_rx_cnt #(
    parameter int CNT_W       = 8,
    parameter int RECOVER_CNT = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_err,
    input  logic             rx_ok,
    input  logic             idle11,
    input  logic             bus_off,
    input  logic             trip,
    output logic [CNT_W-1:0] rec,
    output logic             recover
);
    localparam logic [CNT_W-1:0] RCV_LAST = CNT_W'(RECOVER_CNT - 1);
    localparam logic [CNT_W-1:0] MAX_N    = {CNT_W{1'b1}};

    // Recovery fires on the idle pulse that completes the count
    always_comb begin
        recover = bus_off && idle11 && (rec == RCV_LAST);
    end

    // Counter update; trip or recovery clears, bus off counts idle runs only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec <= '0;
        end else if (trip || recover) begin
            rec <= '0;
        end else if (bus_off) begin
            if (idle11) rec <= rec + 1'b1;
        end else if (rx_err) begin
            if (rec != MAX_N) rec <= rec + 1'b1;
        end else if (rx_ok && (rec != '0)) begin
            rec <= rec - 1'b1;
        end
    end

    // R4: success at zero never wraps
    a_r4_rx_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_off && rx_ok && !rx_err && !trip && rec == '0) |=> (rec == '0));

    // R9: each idle pulse in bus off short of recovery adds one
    a_r9_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && idle11 && !recover) |=> (rec == $past(rec) + 1'b1));

    // R7: entering bus off leaves the idle count at zero
    a_r7_rec_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (rec == '0));
endmodule

// File: rtl/can_fc_state.sv
// Module: fault confinement state keeper.
// It holds the bus-off flag, setting it on trip and clearing it on recover.
// It derives the state code from that flag and from the two counters.
// Assumes trip and recover never coincide, since trip needs the node on the
// bus and recover needs it off.
module can_fc_state
    import can_fc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PASSIVE_LVL = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trip,
    input  logic             recover,
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    output logic             bus_off,
    output fc_state_e        state
);
    localparam logic [CNT_W-1:0] PASS_N = CNT_W'(PASSIVE_LVL);

    // Bus-off flag: set on trip, cleared on recovery
    always_ff @(posedge clk) begin
        if (!rst_n)       bus_off <= 1'b0;
        else if (trip)    bus_off <= 1'b1;
        else if (recover) bus_off <= 1'b0;
    end

    // State code from the flag and the passive threshold
    always_comb begin
        if (bus_off)                                state = FC_BUSOFF;
        else if ((tec >= PASS_N) || (rec >= PASS_N)) state = FC_PASSIVE;
        else                                        state = FC_ACTIVE;
    end

    // R7: a trip leads to bus off on the next cycle
    a_r7_enter_off: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (state == FC_BUSOFF));

    // R10: recovery lands in error active with cleared counters
    a_r10_recover: assert property (@(posedge clk) disable iff (!rst_n)
        recover |=> (state == FC_ACTIVE && tec == '0 && rec == '0));
endmodule

// File: rtl/can_fault_conf.sv
// Module: CAN fault confinement unit (top).
// Connects the transmit counter, the receive/idle counter and the state
// keeper, and packs their results into the read-only status word.
// Assumes the event inputs are one-cycle pulses that are already synchronous
// to clk.
module can_fault_conf
    import can_fc_pkg::*;
#(
    parameter int TX_STEP     = 8,
    parameter int PASSIVE_LVL = 128,
    parameter int WARN_LVL    = 96,
    parameter int RECOVER_CNT = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_tx_err,
    input  logic                ev_rx_err,
    input  logic                ev_tx_ok,
    input  logic                ev_rx_ok,
    input  logic                ev_idle11,
    output logic [STATUS_W-1:0] status_word
);
    localparam logic [CNT_W-1:0] WARN_N = CNT_W'(WARN_LVL);

    logic [CNT_W-1:0] tec;
    logic [CNT_W-1:0] rec;
    logic             trip;
    logic             recover;
    logic             bus_off;
    fc_state_e        state;

    can_fc_tx_cnt #(.CNT_W(CNT_W), .TX_STEP(TX_STEP)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_err  (ev_tx_err),
        .tx_ok   (ev_tx_ok),
        .bus_off (bus_off),
        .recover (recover),
        .tec     (tec),
        .trip    (trip)
    );

    can_fc_rx_cnt #(.CNT_W(CNT_W), .RECOVER_CNT(RECOVER_CNT)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_err  (ev_rx_err),
        .rx_ok   (ev_rx_ok),
        .idle11  (ev_idle11),
        .bus_off (bus_off),
        .trip    (trip),
        .rec     (rec),
        .recover (recover)
    );

    can_fc_state #(.CNT_W(CNT_W), .PASSIVE_LVL(PASSIVE_LVL)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip    (trip),
        .recover (recover),
        .tec     (tec),
        .rec     (rec),
        .bus_off (bus_off),
        .state   (state)
    );

    // Pack counters, state code and warning flags; unused bits stay zero
    always_comb begin
        status_word = '0;
        status_word[TEC_LSB +: CNT_W]   = tec;
        status_word[REC_LSB +: CNT_W]   = rec;
        status_word[STATE_LSB +: 2]     = state;
        status_word[TWARN_BIT]          = (tec >= WARN_N);
        status_word[RWARN_BIT]          = (rec >= WARN_N);
    end

    // R5: the unused code 2'b11 never appears after a clock edge
    a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_word[STATE_LSB +: 2] != 2'b11));

    // R1: reset leaves the whole word cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (status_word == '0));
endmodule

// File: tb/can_fault_conf_tb.sv
module can_fault_conf_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0, idle = 0;
    logic [31:0] status_word;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    int m_tec = 0, m_rec = 0;
    bit m_off = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_fault_conf u_dut (
        .clk(clk), .rst_n(rst_n),
        .ev_tx_err(tx_err), .ev_rx_err(rx_err), .ev_tx_ok(tx_ok),
        .ev_rx_ok(rx_ok), .ev_idle11(idle), .status_word(status_word)
    );

    function automatic logic [31:0] expect_word();
        logic [1:0] code;
        if (m_off) code = 2'b10;
        else if (m_tec >= 128 || m_rec >= 128) code = 2'b01;
        else code = 2'b00;
        return {12'd0, m_rec >= 96, m_tec >= 96, code, 8'(m_rec), 8'(m_tec)};
    endfunction

    // model of one clock edge, written from the requirements
    task automatic model_edge();
        if (!rst_n) begin
            m_tec = 0; m_rec = 0; m_off = 0;
        end else if (m_off) begin
            if (idle) begin
                m_rec++;
                if (m_rec == 128) begin m_rec = 0; m_tec = 0; m_off = 0; end
            end
        end else begin
            if (tx_err) begin
                if (m_tec + 8 > 255) begin m_tec = 255; m_off = 1; end
                else m_tec += 8;
            end else if (tx_ok && m_tec > 0) m_tec--;
            if (m_off) m_rec = 0;
            else if (rx_err) begin if (m_rec < 255) m_rec++; end
            else if (rx_ok && m_rec > 0) m_rec--;
        end
    endtask

    task automatic compare(string tag);
        logic [31:0] exp;
        exp = expect_word();
        checks++;
        if (status_word !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, status_word, exp);
        end
    endtask

    // apply one cycle of events at a falling edge, check at the next one
    task automatic step(string tag, bit te, bit re, bit to, bit ro, bit id);
        tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro; idle = id;
        model_edge();
        @(negedge clk);
        compare(tag);
        tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; idle = 0;
    endtask

    task automatic check_field(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) step("R1 reset", 1, 1, 0, 0, 1);
        check_field("R1 reset word", int'(status_word), 0);
        rst_n = 1;

        // R9: idle pulses outside bus off are ignored
        repeat (4) step("R9 idle ignored", 0, 0, 0, 0, 1);
        check_field("R9 rec after idle on bus", int'(status_word[15:8]), 0);

        // R2 transmit steps, R3 decrement and floor
        repeat (5) step("R2 tx step", 1, 0, 0, 0, 0);
        check_field("R2 tec", int'(status_word[7:0]), 40);
        step("R3 err beats ok", 1, 0, 1, 0, 0);
        check_field("R3 tec", int'(status_word[7:0]), 48);
        repeat (50) step("R3 tx floor", 0, 0, 1, 0, 0);
        check_field("R3 tec floor", int'(status_word[7:0]), 0);

        // R4 receive floor, warning and saturation
        repeat (3) step("R4 rx floor", 0, 0, 0, 1, 0);
        step("R4 err beats ok", 0, 1, 0, 1, 0);
        check_field("R4 rec", int'(status_word[15:8]), 1);
        repeat (94) step("R6 rx warn", 0, 1, 0, 0, 0);
        check_field("R6 rx warn at 95", int'(status_word[19]), 0);
        step("R6 rx warn", 0, 1, 0, 0, 0);
        check_field("R6 rx warn at 96", int'(status_word[19]), 1);
        repeat (32) step("R5 rx passive", 0, 1, 0, 0, 0);
        check_field("R5 passive code", int'(status_word[17:16]), 1);
        repeat (140) step("R4 rx saturate", 0, 1, 0, 0, 0);
        check_field("R4 rec saturated", int'(status_word[15:8]), 255);
        repeat (130) step("R5 back active", 0, 0, 0, 1, 0);
        check_field("R5 active code", int'(status_word[17:16]), 0);
        repeat (130) step("R4 rx down", 0, 0, 0, 1, 0);

        // R6 tx warn and R7 bus off entry
        repeat (12) step("R6 tx warn", 1, 0, 0, 0, 0);
        check_field("R6 tx warn at 96", int'(status_word[18]), 1);
        repeat (3) step("R7 rx before off", 0, 1, 0, 0, 0);
        repeat (19) step("R7 climb", 1, 0, 0, 0, 0);
        check_field("R7 tec 248", int'(status_word[7:0]), 248);
        step("R7 trip", 1, 0, 0, 0, 0);
        check_field("R7 code", int'(status_word[17:16]), 2);
        check_field("R7 tec pinned", int'(status_word[7:0]), 255);
        check_field("R7 rec cleared", int'(status_word[15:8]), 0);

        // R8 events ignored during bus off
        step("R8 ignore", 1, 0, 0, 0, 0);
        step("R8 ignore", 0, 1, 0, 0, 0);
        step("R8 ignore", 0, 0, 1, 0, 0);
        step("R8 ignore", 0, 0, 0, 1, 0);
        check_field("R8 rec unchanged", int'(status_word[15:8]), 0);

        // R9 idle counting, R10 recovery on the 128th
        repeat (127) step("R9 idle count", 0, 0, 0, 0, 1);
        check_field("R9 rec 127", int'(status_word[15:8]), 127);
        check_field("R9 still off", int'(status_word[17:16]), 2);
        step("R10 recover", 0, 0, 0, 0, 1);
        check_field("R10 word cleared", int'(status_word), 0);

        // random mix, weighted to reach bus off repeatedly
        for (int i = 0; i < 6000; i++) begin
            bit te, re, to, ro, id;
            te = ($urandom_range(0, 99) < 45);
            re = ($urandom_range(0, 99) < 30);
            to = ($urandom_range(0, 99) < 30);
            ro = ($urandom_range(0, 99) < 30);
            id = ($urandom_range(0, 99) < 70);
            step("R11 random word", te, re, to, ro, id);
        end

        // R1 reset in mid-run
        rst_n = 0;
        step("R1 mid reset", 1, 0, 0, 0, 0);
        rst_n = 1;
        check_field("R1 mid reset word", int'(status_word), 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule